// File: doc/BRIEF.md
# Flash Status Busy-Poll Engine

This block waits out the internal program or erase cycle of a serial NOR flash. A one-cycle `start` pulse arms a deadline counter from `tmo_max`. The block then asks an external single-lane SPI sequencer to run a status read: an 8-cycle command phase with opcode 0x05, a 4-byte data read, and a stop. Each time the sequencer hands back a status byte, the block judges it. The device may be idle, it may report a program or erase failure (this check can be switched off), or the deadline may have run out. If none of these holds, the block launches the read again.

The controller is a four-state machine. ST_IDLE goes to ST_ISSUE on `start`. ST_ISSUE always goes to ST_WAIT after one cycle, and it emits the launch pulse and notes whether the deadline has already been reached. In ST_WAIT the block waits for `rs_valid`. From there it goes back to ST_ISSUE if the device is still busy and time remains (the "again" verdict). Otherwise it goes to ST_DONE on one of three verdicts: idle, fault or expired. ST_DONE always returns to ST_IDLE after one cycle and pulses `done`. The result byte and the timeout flag are held until the next completion.

Top module: `flash_busy_poll`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it, `done`, `busy`, `rq_launch`, `timed_out` are 0 and `result` is 0x00.
- R2: A returned status with bit 0 (busy flag) clear ends the poll with `result` 0x00. This holds even when the error bits are set.
- R3: When `err_chk_en` is 1 and a busy status has bit 6 (program error) or bit 5 (erase error) set, the poll ends at once with `result` equal to that status byte.
- R4: When `err_chk_en` is 0, bits 6 and 5 have no effect and polling continues while bit 0 is set.
- R5: Every busy status that does not end the poll causes a new one-cycle `rq_launch` in the cycle after `rs_valid` is sampled. The first launch comes in the cycle after `start` is sampled.
- R6: The request fields are constant: `rq_opcode` = 0x05, `rq_cmd_cycles` = 8, `rq_rd_bytes` = 4.
- R7: The deadline counter is loaded with `tmo_max` when `start` is accepted. It counts down by one in every polling cycle and stops at 0. A launch made while the counter reads 0 is the last try.
- R8: If the last try returns a busy status (and no enabled error bit is set), `result` is 0xFF and `timed_out` is 1. Every other completion leaves `timed_out` at 0.
- R9: `start` is ignored while `busy` is 1.
- R10: `done` is high for exactly one cycle, the cycle after the deciding `rs_valid`. `result` and `timed_out` change only in that cycle and hold afterwards.
- R11: `busy` is 1 from the cycle after `start` is accepted through the `done` cycle inclusive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| start | input | 1 | begin a poll (pulse) |
| err_chk_en | input | 1 | enable program/erase error exit |
| tmo_max | input | TMO_W | deadline in polling cycles |
| rq_launch | output | 1 | one-cycle request to run a status read |
| rq_opcode | output | 8 | command opcode of the read |
| rq_cmd_cycles | output | CYC_W | command-phase length in clocks |
| rq_rd_bytes | output | BYTE_W | data bytes requested per read |
| rs_valid | input | 1 | status byte returned |
| rs_status | input | 8 | returned status byte |
| done | output | 1 | one-cycle completion pulse |
| result | output | 8 | 0x00 idle, status on error, 0xFF on timeout |
| timed_out | output | 1 | last completion was a timeout |
| busy | output | 1 | poll in progress |

## Verification
The timing is fixed. The launch is due one cycle after `start` or after a continuing `rs_valid`. `done`, `result` and `timed_out` are due one cycle after the deciding `rs_valid`. The bench's behavioural model advances on each rising edge from the same inputs. Every output is compared with that model at the following falling edge, so each result is checked in exactly the cycle it is due. The responder answers each launch two cycles later. This makes a poll iteration three cycles long, so the deadline boundary can be checked with exact launch counts: `tmo_max` 10 gives 5 launches and `tmo_max` 9 gives 4.

// File: rtl/fbp_pkg.sv
package fbp_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT,
        ST_DONE
    } fbp_state_e;

    typedef enum logic [1:0] {
        VD_AGAIN,
        VD_IDLE,
        VD_FAULT,
        VD_EXPIRED
    } fbp_verdict_e;

    localparam logic [7:0] EXPIRED_CODE = 8'hFF;
endpackage

// File: rtl/fbp_deadline.sv
module fbp_deadline #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         run,
    output logic         expired
);
    logic [W-1:0] remain;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain <= '0;
        end else if (load) begin
            remain <= load_val;
        end else if (run && remain != '0) begin
            remain <= remain - 1'b1;
        end
    end

    assign expired = (remain == '0);
endmodule

// File: rtl/fbp_status_eval.sv
module fbp_status_eval
    import fbp_pkg::*;
#(
    parameter int BUSY_BIT = 0,
    parameter int PERR_BIT = 6,
    parameter int EERR_BIT = 5
) (
    input  logic [7:0]   status,
    input  logic         chk_en,
    input  logic         last_try,
    output fbp_verdict_e verdict
);
    localparam logic [7:0] ERR_MASK = (8'h01 << PERR_BIT) | (8'h01 << EERR_BIT);

    always_comb begin
        if (!status[BUSY_BIT]) begin
            verdict = VD_IDLE;
        end else if (chk_en && ((status & ERR_MASK) != 8'h00)) begin
            verdict = VD_FAULT;
        end else if (last_try) begin
            verdict = VD_EXPIRED;
        end else begin
            verdict = VD_AGAIN;
        end
    end
endmodule

// File: rtl/flash_busy_poll.sv
module flash_busy_poll
    import fbp_pkg::*;
#(
    parameter int         TMO_W    = 16,
    parameter int         PERR_BIT = 6,
    parameter int         EERR_BIT = 5,
    parameter logic [7:0] OPCODE   = 8'h05,
    parameter int         CMD_CYC  = 8,
    parameter int         RD_BYTES = 4,
    parameter int         CYC_W    = 4,
    parameter int         BYTE_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              err_chk_en,
    input  logic [TMO_W-1:0]  tmo_max,
    output logic              rq_launch,
    output logic [7:0]        rq_opcode,
    output logic [CYC_W-1:0]  rq_cmd_cycles,
    output logic [BYTE_W-1:0] rq_rd_bytes,
    input  logic              rs_valid,
    input  logic [7:0]        rs_status,
    output logic              done,
    output logic [7:0]        result,
    output logic              timed_out,
    output logic              busy
);
    localparam int BUSY_BIT = 0;

    fbp_state_e   state, state_nxt;
    fbp_verdict_e verdict;
    logic         expired;
    logic         last_try;
    logic         accept;
    logic         decide;

    assign accept = (state == ST_IDLE) && start;
    assign decide = (state == ST_WAIT) && rs_valid;

    fbp_deadline #(.W(TMO_W)) u_deadline (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .load_val (tmo_max),
        .run      ((state == ST_ISSUE) || (state == ST_WAIT)),
        .expired  (expired)
    );

    fbp_status_eval #(
        .BUSY_BIT (BUSY_BIT),
        .PERR_BIT (PERR_BIT),
        .EERR_BIT (EERR_BIT)
    ) u_eval (
        .status   (rs_status),
        .chk_en   (err_chk_en),
        .last_try (last_try),
        .verdict  (verdict)
    );

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE:  if (start) state_nxt = ST_ISSUE;
            ST_ISSUE: state_nxt = ST_WAIT;
            ST_WAIT:  if (rs_valid) state_nxt = (verdict == VD_AGAIN) ? ST_ISSUE : ST_DONE;
            ST_DONE:  state_nxt = ST_IDLE;
            default:  state_nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            last_try  <= 1'b0;
            result    <= 8'h00;
            timed_out <= 1'b0;
        end else begin
            state <= state_nxt;
            if (state == ST_ISSUE) begin
                last_try <= expired;
            end
            if (decide && verdict != VD_AGAIN) begin
                unique case (verdict)
                    VD_IDLE:    result <= 8'h00;
                    VD_FAULT:   result <= rs_status;
                    VD_EXPIRED: result <= EXPIRED_CODE;
                    default:    result <= 8'h00;
                endcase
                timed_out <= (verdict == VD_EXPIRED);
            end
        end
    end

    always_comb begin
        rq_launch     = (state == ST_ISSUE);
        done          = (state == ST_DONE);
        busy          = (state != ST_IDLE);
        rq_opcode     = OPCODE;
        rq_cmd_cycles = CYC_W'(CMD_CYC);
        rq_rd_bytes   = BYTE_W'(RD_BYTES);
    end
endmodule

// File: rtl/fbp_checker.sv
module fbp_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       busy,
    input logic       done,
    input logic       rq_launch,
    input logic [7:0] result,
    input logic       timed_out
);
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R10
    AST_LAUNCH_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rq_launch |=> !rq_launch); // R5
    AST_EXPIRED_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (done && timed_out) |-> (result == 8'hFF)); // R8
    AST_LAUNCH_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        rq_launch |-> busy); // R11
    AST_NO_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy); // R9
    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(result) |-> done); // R10
endmodule

bind flash_busy_poll fbp_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .done      (done),
    .rq_launch (rq_launch),
    .result    (result),
    .timed_out (timed_out)
);

// File: tb/flash_busy_poll_tb.sv
module flash_busy_poll_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        err_chk_en = 1'b0;
    logic [15:0] tmo_max = 16'd0;
    logic        rq_launch;
    logic [7:0]  rq_opcode;
    logic [3:0]  rq_cmd_cycles;
    logic [2:0]  rq_rd_bytes;
    logic        rs_valid = 1'b0;
    logic [7:0]  rs_status = 8'h00;
    logic        done;
    logic [7:0]  result;
    logic        timed_out;
    logic        busy;

    integer errors = 0;
    integer checks = 0;
    integer n_launch = 0;
    integer resp_cd = 0;
    logic [7:0] stat_q[$];
    bit finished = 0;

    always #5 clk = ~clk;

    flash_busy_poll u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .err_chk_en(err_chk_en),
        .tmo_max(tmo_max), .rq_launch(rq_launch), .rq_opcode(rq_opcode),
        .rq_cmd_cycles(rq_cmd_cycles), .rq_rd_bytes(rq_rd_bytes),
        .rs_valid(rs_valid), .rs_status(rs_status), .done(done),
        .result(result), .timed_out(timed_out), .busy(busy)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // behavioural reference: phase 0 idle, 1 launch, 2 waiting, 3 finished
    integer     m_ph = 0;
    integer     m_left = 0;
    bit         m_last = 0;
    logic [7:0] m_res = 8'h00;
    bit         m_tmo = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph = 0; m_left = 0; m_last = 0; m_res = 8'h00; m_tmo = 0;
        end else begin
            case (m_ph)
                0: if (start) begin m_left = tmo_max; m_ph = 1; end
                1: begin
                    m_last = (m_left == 0);
                    if (m_left > 0) m_left = m_left - 1;
                    m_ph = 2;
                end
                2: begin
                    if (m_left > 0) m_left = m_left - 1;
                    if (rs_valid) begin
                        if (rs_status[0] == 1'b0) begin
                            m_res = 8'h00; m_tmo = 0; m_ph = 3;
                        end else if (err_chk_en && (rs_status[6] || rs_status[5])) begin
                            m_res = rs_status; m_tmo = 0; m_ph = 3;
                        end else if (m_last) begin
                            m_res = 8'hFF; m_tmo = 1; m_ph = 3;
                        end else begin
                            m_ph = 1;
                        end
                    end
                end
                default: m_ph = 0;
            endcase
        end
    end

    // per-cycle comparison against the model, away from the rising edge
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk("R5 launch", rq_launch, m_ph == 1);
            chk("R10 done", done, m_ph == 3);
            chk("R11 busy", busy, m_ph != 0);
            chk("R2 R3 R8 result", result, m_res);
            chk("R8 timed_out", timed_out, m_tmo);
        end
    end

    // SPI master stand-in: answers each launch two cycles later
    always @(negedge clk) begin
        rs_valid <= 1'b0;
        if (rq_launch) begin
            n_launch = n_launch + 1;
            resp_cd = 2;
        end else if (resp_cd == 1) begin
            resp_cd = 0;
            rs_valid <= 1'b1;
            if (stat_q.size() > 0) rs_status <= stat_q.pop_front();
            else rs_status <= 8'h01;
        end else if (resp_cd > 1) begin
            resp_cd = resp_cd - 1;
        end
    end

    task automatic run_poll(input bit en, input int tmax, input int mid_start);
        err_chk_en = en;
        tmo_max = 16'(tmax);
        @(negedge clk);
        n_launch = 0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 3000; i++) begin
            if (i == mid_start) start = 1'b1;
            else start = 1'b0;
            if (done) break;
            @(negedge clk);
        end
        start = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 done", done, 0);
        chk("R1 busy", busy, 0);
        chk("R1 launch", rq_launch, 0);
        chk("R1 result", result, 0);
        chk("R1 timed_out", timed_out, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 busy after release", busy, 0);
        chk("R6 opcode", rq_opcode, 8'h05);
        chk("R6 cmd cycles", rq_cmd_cycles, 8);
        chk("R6 data bytes", rq_rd_bytes, 4);

        // three busy reads then idle
        stat_q = '{8'h01, 8'h01, 8'h01, 8'h00};
        run_poll(1, 1000, -1);
        chk("R2 idle result", result, 8'h00);
        chk("R5 relaunch count", n_launch, 4);
        @(negedge clk);
        @(negedge clk);
        chk("R10 result held", result, 8'h00);

        // idle flag wins over error bits
        stat_q = '{8'h60};
        run_poll(1, 1000, -1);
        chk("R2 idle with error bits", result, 8'h00);

        // program error exit
        stat_q = '{8'h01, 8'h41};
        run_poll(1, 1000, -1);
        chk("R3 program error", result, 8'h41);
        chk("R3 launches", n_launch, 2);
        chk("R8 no timeout flag", timed_out, 0);

        // erase error exit
        stat_q = '{8'h23};
        run_poll(1, 1000, -1);
        chk("R3 erase error", result, 8'h23);

        // error bits ignored when checking is off
        stat_q = '{8'h41, 8'h21, 8'h00};
        run_poll(0, 1000, -1);
        chk("R4 error ignored", result, 8'h00);
        chk("R4 launches", n_launch, 3);

        // zero deadline: exactly one read then timeout
        stat_q.delete();
        run_poll(1, 0, -1);
        chk("R8 timeout code", result, 8'hFF);
        chk("R8 timeout flag", timed_out, 1);
        chk("R7 single try", n_launch, 1);

        // deadline boundaries with a three-cycle iteration
        run_poll(1, 10, -1);
        chk("R7 launches tmo 10", n_launch, 5);
        chk("R8 code tmo 10", result, 8'hFF);
        run_poll(1, 9, -1);
        chk("R7 launches tmo 9", n_launch, 4);

        // start pulses during a poll are ignored
        stat_q = '{8'h01, 8'h01, 8'h00};
        run_poll(1, 1000, 2);
        chk("R9 launches", n_launch, 3);
        chk("R9 result", result, 8'h00);
        chk("R8 flag cleared", timed_out, 0);
        repeat (4) @(negedge clk);
        chk("R9 idle after", busy, 0);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule